// File: doc/BRIEF.md
# Two-Tier Fixed-Priority Service Arbiter

This block decides which of several clients may use a single shared control engine. Four burst-mode ports each raise two request lines: an urgent one, used when a data buffer must be refilled or drained, and a lower one for housekeeping. Housekeeping covers fetching the next chained command, building end-of-operation status, and prefetching one or two doublewords when a write starts. Three other requesters take part: the interface that carries multiplexed traffic, the engine itself, and the host. The arbiter places urgent port requests above the multiplexed interface, and that interface above the housekeeping requests. The engine and the host rank below all of them.

A winner keeps the engine until it pulses a release strobe. Each grant covers only one segment of an operation, so other requesters can break in between segments. While a grant is held, no new arbitration takes place. On the clock edge where release is sampled, the arbiter grants again from the requests present at that moment. The arbiter stores no request: a client that withdraws before it is chosen is not served. A hold timer compares the length of the current grant against a limit set at run time and raises an error flag when the grant has been held too long.

Top module: `svc_arbiter`

## Requirements
- R1: While reset is asserted and until the reset release has passed its two-stage synchronizer, `grant` is zero and `busy` and `prio_err` are low.
- R2: Rank index i is also grant bit i. Indices 0 to P-1 are the urgent requests of ports 1 to P. Index P is the multiplexed interface. Indices P+1 to 2P are the housekeeping requests of ports 1 to P. Index 2P+1 is the engine and index 2P+2 is the host. The lowest active index wins.
- R3: At most one bit of `grant` is set at any time.
- R4: When `busy` is low, each clock edge loads `grant` with the winner among the requests sampled at that edge. With no request active, `grant` stays zero.
- R5: While `busy` is high and `release_i` is low, `grant` holds its value whatever the request lines do.
- R6: An edge with `busy` and `release_i` both high reloads `grant` from the requests sampled at that edge. The releasing client may be granted again if it still wins. With no request active, `grant` becomes zero. `release_i` sampled while `busy` is low has no effect beyond the idle behaviour of R4.
- R7: The arbiter keeps no memory of requests. A request raised during a grant and dropped before the reloading edge is never granted.
- R8: `busy` is high exactly when some bit of `grant` is set.
- R9: The hold count is zero in the first cycle of a grant and rises by one per held cycle, saturating at its maximum. `prio_err` is high while `busy` is high and the hold count is at least `hold_limit`. It falls on the edge that reloads `grant`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized inside |
| urg_req | input | NUM_PORTS | Urgent buffer-service request per burst port (bit 0 = port 1) |
| mux_req | input | 1 | Request from the multiplexed-port interface |
| hk_req | input | NUM_PORTS | Housekeeping request per burst port (bit 0 = port 1) |
| eng_req | input | 1 | Engine-internal request |
| host_req | input | 1 | Host request |
| release_i | input | 1 | Current grant holder ends its segment |
| hold_limit | input | CNT_W | Held-cycle count at which `prio_err` rises |
| grant | output | 2*NUM_PORTS+3 | One-hot registered grant in rank order |
| busy | output | 1 | A grant is active |
| prio_err | output | 1 | Current grant has been held too long |

## Verification
The properties assume that requests and `release_i` are sampled only at rising edges. They also assume that `release_i` means something only while `busy` is high, so a release pulse seen while idle must not change the outcome. The stimulus changes every input on the falling edge, away from the sampling edge. It pulses release while idle on purpose, both in directed cases and in random traffic, to show that such pulses change nothing. It keeps `hold_limit` well below the counter's saturation value, so the timeout comparison is never hidden by saturation.

// File: rtl/svc_arb_pkg.sv
package svc_arb_pkg;

  // Number of rank slots for a given number of burst ports.
  function automatic int unsigned slot_count(input int unsigned ports);
    return 2 * ports + 3;
  endfunction

  function automatic int unsigned mux_slot(input int unsigned ports);
    return ports;
  endfunction

  function automatic int unsigned hk_base(input int unsigned ports);
    return ports + 1;
  endfunction

  function automatic int unsigned eng_slot(input int unsigned ports);
    return 2 * ports + 1;
  endfunction

  function automatic int unsigned host_slot(input int unsigned ports);
    return 2 * ports + 2;
  endfunction

endpackage

// File: rtl/arb_rst_sync.sv
module arb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/arb_req_order.sv
module arb_req_order
  import svc_arb_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  localparam int NUM_REQ  = 2 * NUM_PORTS + 3
) (
  input  logic [NUM_PORTS-1:0] urg_req,
  input  logic                 mux_req,
  input  logic [NUM_PORTS-1:0] hk_req,
  input  logic                 eng_req,
  input  logic                 host_req,
  output logic [NUM_REQ-1:0]   rank_vec
);

  localparam int MUX_IDX  = int'(mux_slot(NUM_PORTS));
  localparam int HK_IDX   = int'(hk_base(NUM_PORTS));
  localparam int ENG_IDX  = int'(eng_slot(NUM_PORTS));
  localparam int HOST_IDX = int'(host_slot(NUM_PORTS));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign rank_vec[p]          = urg_req[p];
    assign rank_vec[HK_IDX + p] = hk_req[p];
  end

  assign rank_vec[MUX_IDX]  = mux_req;
  assign rank_vec[ENG_IDX]  = eng_req;
  assign rank_vec[HOST_IDX] = host_req;

endmodule

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
  parameter int WIDTH = 11
) (
  input  logic [WIDTH-1:0] req,
  output logic [WIDTH-1:0] pick
);

  logic [WIDTH:0] seen;

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_chain
    assign pick[i]     = req[i] & ~seen[i];
    assign seen[i + 1] = seen[i] | req[i];
  end

endmodule

// File: rtl/arb_hold_timer.sv
module arb_hold_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             held,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             at_max;

  assign at_max = &cnt_q;

  always_comb begin
    cnt_en = load | (held & ~at_max);
    if (load) cnt_d = '0;
    else      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = held & (cnt_q >= limit);

endmodule

// File: rtl/svc_arbiter.sv
module svc_arbiter #(
  parameter int NUM_PORTS = 4,
  parameter int CNT_W     = 16,
  localparam int NUM_REQ  = 2 * NUM_PORTS + 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] urg_req,
  input  logic                 mux_req,
  input  logic [NUM_PORTS-1:0] hk_req,
  input  logic                 eng_req,
  input  logic                 host_req,
  input  logic                 release_i,
  input  logic [CNT_W-1:0]     hold_limit,
  output logic [NUM_REQ-1:0]   grant,
  output logic                 busy,
  output logic                 prio_err
);

  logic               rst_sync_n;
  logic [NUM_REQ-1:0] req_rank;
  logic [NUM_REQ-1:0] winner;
  logic [NUM_REQ-1:0] grant_q;
  logic [NUM_REQ-1:0] grant_d;
  logic               load_en;
  logic               held;

  arb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_sync_n)
  );

  arb_req_order #(.NUM_PORTS(NUM_PORTS)) u_order (
    .urg_req  (urg_req),
    .mux_req  (mux_req),
    .hk_req   (hk_req),
    .eng_req  (eng_req),
    .host_req (host_req),
    .rank_vec (req_rank)
  );

  arb_prio_pick #(.WIDTH(NUM_REQ)) u_pick (
    .req  (req_rank),
    .pick (winner)
  );

  assign held    = |grant_q;
  assign load_en = ~held | release_i;

  always_comb begin
    grant_d = winner;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  grant_q <= '0;
    else if (load_en) grant_q <= grant_d;
  end

  arb_hold_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (load_en),
    .held    (held),
    .limit   (hold_limit),
    .expired (prio_err)
  );

  assign grant = grant_q;
  assign busy  = held;

endmodule

// File: rtl/svc_arbiter_chk.sv
module svc_arbiter_chk #(
  parameter int NUM_REQ = 11
) (
  input logic               clk,
  input logic               rst_ok_n,
  input logic [NUM_REQ-1:0] req_rank,
  input logic               release_i,
  input logic [NUM_REQ-1:0] grant,
  input logic               busy,
  input logic               prio_err
);

  logic may_load;
  assign may_load = !busy || release_i;

  assert_single_grant_R3: assert property (@(posedge clk) disable iff (!rst_ok_n)
    $onehot0(grant));

  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (busy && !release_i) |=> $stable(grant));

  assert_load_when_req_R4: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (may_load && (req_rank != '0)) |=> busy);

  assert_top_rank_R2: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (may_load && req_rank[0]) |=> grant[0]);

  assert_no_req_idle_R6: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (may_load && (req_rank == '0)) |=> !busy);

  assert_only_requested_R7: assert property (@(posedge clk) disable iff (!rst_ok_n)
    may_load |=> ((grant & ~$past(req_rank)) == '0));

  assert_err_needs_grant_R9: assert property (@(posedge clk) disable iff (!rst_ok_n)
    prio_err |-> busy);

  assert_err_clears_on_load_R9: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (may_load && (req_rank == '0)) |=> !prio_err);

endmodule

bind svc_arbiter svc_arbiter_chk #(.NUM_REQ(NUM_REQ)) u_chk (
  .clk       (clk),
  .rst_ok_n  (rst_sync_n),
  .req_rank  (req_rank),
  .release_i (release_i),
  .grant     (grant),
  .busy      (busy),
  .prio_err  (prio_err)
);

// File: tb/svc_arbiter_bench.sv
`timescale 1ns/1ps
module svc_arbiter_bench;

  localparam int P  = 4;
  localparam int CW = 16;
  localparam int N  = 2 * P + 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  req_v;
  logic          rel;
  logic [CW-1:0] lim;

  logic [P-1:0]  urg, hk;
  logic          mux, eng, host;
  logic [N-1:0]  grant;
  logic          busy, prio_err;

  assign urg  = req_v[P-1:0];
  assign mux  = req_v[P];
  assign hk   = req_v[2*P:P+1];
  assign eng  = req_v[2*P+1];
  assign host = req_v[2*P+2];

  always #2 clk = ~clk;

  svc_arbiter #(.NUM_PORTS(P), .CNT_W(CW)) u_svc_arbiter (
    .clk(clk), .rst_n(rst_n), .urg_req(urg), .mux_req(mux), .hk_req(hk),
    .eng_req(eng), .host_req(host), .release_i(rel), .hold_limit(lim),
    .grant(grant), .busy(busy), .prio_err(prio_err)
  );

  // Behavioural reference: index of holder (-1 idle) and held-cycle count.
  int m_idx;
  int m_cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_idx = -1;
      m_cnt = 0;
    end else if (m_idx < 0 || rel) begin
      m_idx = -1;
      for (int i = N - 1; i >= 0; i--) if (req_v[i]) m_idx = i;
      m_cnt = 0;
    end else if (m_cnt < (1 << CW) - 1) begin
      m_cnt = m_cnt + 1;
    end
  end

  int    n_vec = 0;
  int    n_bad = 0;
  bit    done  = 0;
  string tag   = "R1";

  task automatic check_now();
    logic [N-1:0] eg;
    logic         eb, ee;
    eg = '0;
    if (m_idx >= 0) eg[m_idx] = 1'b1;
    eb = (m_idx >= 0);
    ee = eb && (m_cnt >= int'(lim));
    n_vec++;
    if (grant !== eg || busy !== eb || prio_err !== ee) begin
      n_bad++;
      $display("FAIL %s grant=%b busy=%b err=%b expected grant=%b busy=%b err=%b",
               tag, grant, busy, prio_err, eg, eb, ee);
    end
    n_vec++;
    if ($countones(grant) > 1) begin
      n_bad++;
      $display("FAIL R3 grant=%b expected at most one bit", grant);
    end
    n_vec++;
    if (busy !== (grant != '0)) begin
      n_bad++;
      $display("FAIL R8 busy=%b expected %b", busy, (grant != '0));
    end
  endtask

  task automatic cyc(input logic [N-1:0] v, input logic r);
    @(negedge clk);
    check_now();
    req_v = v;
    rel   = r;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired, expected run to end");
    finish_run();
  end

  localparam logic [N-1:0] ALL = '1;

  initial begin
    rst_n = 1'b0;
    req_v = '0;
    rel   = 1'b0;
    lim   = 16'd40;
    // R1: reset values while reset asserted
    tag = "R1";
    repeat (3) begin @(negedge clk); check_now(); end
    rst_n = 1'b1;
    repeat (4) cyc('0, 1'b0);

    // R2: each requester alone, then released
    tag = "R2";
    for (int i = 0; i < N; i++) begin
      cyc(N'(1) << i, 1'b0);
      cyc('0, 1'b0);
      cyc('0, 1'b1);
      cyc('0, 1'b0);
    end

    // R4: several competing patterns while idle
    tag = "R4";
    cyc(11'b10000110000, 1'b0); cyc('0, 1'b0); cyc('0, 1'b1);
    cyc(ALL,             1'b0); cyc('0, 1'b0); cyc('0, 1'b1);
    cyc(11'b11000000000, 1'b0); cyc('0, 1'b0); cyc('0, 1'b1);
    cyc(11'b00111100000, 1'b0); cyc('0, 1'b0); cyc('0, 1'b1);
    cyc(11'b00000011000, 1'b0); cyc('0, 1'b0); cyc('0, 1'b1);
    cyc(11'b01000010000, 1'b0); cyc('0, 1'b0); cyc('0, 1'b1);
    cyc('0, 1'b0);

    // R5: held grant ignores higher-ranked arrivals
    tag = "R5";
    cyc(N'(1) << 8, 1'b0);
    repeat (4) cyc(ALL, 1'b0);
    // R6: release hands over to the winner present at that edge
    tag = "R6";
    cyc(ALL, 1'b1);
    cyc(N'(1) << 2, 1'b1);
    cyc('0, 1'b1);
    cyc('0, 1'b1);
    cyc('0, 1'b0);
    cyc(N'(1) << 5, 1'b0);
    cyc(N'(1) << 5, 1'b1);
    cyc('0, 1'b1);
    cyc('0, 1'b0);

    // R7: request withdrawn before the reload edge is never served
    tag = "R7";
    cyc(N'(1) << 10, 1'b0);
    cyc((N'(1) << 9) | (N'(1) << 10), 1'b0);
    cyc(N'(1) << 10, 1'b0);
    cyc(N'(1) << 10, 1'b1);
    cyc('0, 1'b1);
    cyc('0, 1'b0);

    // R9: hold timeout flag rises and clears on reload
    tag = "R9";
    lim = 16'd5;
    cyc(N'(1) << 3, 1'b0);
    repeat (8) cyc('0, 1'b0);
    cyc(N'(1) << 1, 1'b1);
    repeat (3) cyc('0, 1'b0);
    cyc('0, 1'b1);
    lim = 16'd0;
    cyc(N'(1) << 4, 1'b0);
    repeat (2) cyc('0, 1'b0);
    cyc('0, 1'b1);
    cyc('0, 1'b0);

    // R3 R8 plus all others: random traffic
    tag = "R3 R8 random";
    for (int k = 0; k < 4000; k++) begin
      if (k % 250 == 0) lim = CW'($urandom_range(1, 12));
      cyc(N'($urandom() & $urandom() & $urandom()), ($urandom_range(0, 3) == 0));
    end
    cyc('0, 1'b1);
    cyc('0, 1'b0);
    finish_run();
  end

endmodule